// File: doc/BRIEF.md
# Command-Driven I2C Target with Fixed-Length Records

This block is an I2C target that sits on the open-drain SCL and SDA lines and samples them with a fast system clock. It answers one fixed 7-bit address. The first byte written after the block is idle is read as a command code. That code selects one of three records of fixed length and sets the direction of the next transfer.

Codes 0 to 2 arm a read of one of the block's own constant records. Codes 3 to 5 arm a write into one of three records that the controller supplies. Written bytes collect in a staging buffer. They reach their record in one step, and only once the full record has arrived. The armed state survives start, repeated start and stop conditions, so a controller may write a command, issue a repeated start and then read.

The block exposes the controller-supplied records as a flat status vector. It also has a one-cycle completion pulse, and two level flags that show whether a start or a stop was the most recent bus condition. The block never stretches the clock.

Top module: `i2c_cmd_responder`

## Requirements
- R1: Only address 0x48 is answered. A start followed by any other address gets no ACK. SDA then stays released until the next start, and no record, armed state or pulse changes.
- R2: Command codes 0, 1 and 2 arm a read of 1, 2 and 6 bytes, taken from constant records {12}, {15, 16} and {0x41, 0x42, 0x43, 0x44, 0x31, 0x32}. They are sent most significant bit first, starting at byte 0.
- R3: Command codes 3, 4 and 5 arm a write of 1, 2 and 6 bytes into controller record 0, 1 and 2. On rxRecords, record 0 is byte 0, record 1 is bytes 1 to 2, and record 2 is bytes 3 to 8. Byte g sits at bits [8g+7:8g].
- R4: Written bytes go to a staging buffer of at most 20 bytes. A record changes only after its last byte arrives. A write cut short by a stop leaves the record untouched, and the count carries on into the next transaction.
- R5: When the armed byte count reaches zero, the block goes back to waiting for a command. The next written byte is a command, and further read bytes return 0xFF.
- R6: A command code of 6 or more changes nothing, and the next written byte is again taken as a command.
- R7: The block pulls SDA low for the ninth clock after a matching address and after every written byte. It changes SDA only while SCL is low.
- R8: A controller NACK on a read byte before the armed count is used up ends the read. The block returns to command wait with no completion pulse, and later reads return 0xFF.
- R9: startFlag sets and stopFlag clears on a start condition (SDA falling with SCL high). stopFlag sets and startFlag clears on a stop condition (SDA rising with SCL high). Both are 0 after reset.
- R10: donePulse is high for exactly one cycle each time a whole record has been received or its last byte has been read.
- R11: After reset, rxRecords is all zero, SDA is released and donePulse is low.
- R12: While a read is armed, written data bytes are acknowledged and discarded. They neither change the armed record nor count as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| rxRecords | output | 72 | Controller-supplied records, layout per R3 |
| donePulse | output | 1 | One-cycle pulse when a record transfer completes |
| startFlag | output | 1 | Last bus condition seen was a start |
| stopFlag | output | 1 | Last bus condition seen was a stop |

## Verification
The assertions check on every cycle that:
- the start and stop flags are never both set;
- the completion pulse never lasts two cycles;
- a record commit always directly follows a staging write at an index inside the buffer;
- SDA is released after a stop;
- the SDA drive never changes while SCL is high.

Only the bench's scenarios can show the rest. This covers the command decode, the returned byte values, and writes that are deferred across a stop. It also covers the return to command wait after the count, an invalid code or an early NACK, and how the block ignores foreign addresses and writes while a read is armed. These are checked against a behavioural model of records and armed state.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
  localparam int NUM_REC   = 3;
  localparam int REC_BYTES = 9;
  localparam int LEN_W     = 3;

  typedef enum logic [1:0] {MODE_CMD, MODE_TX, MODE_RX} modeT;

  typedef struct packed {
    logic       shiftIn;
    logic       shiftOut;
    logic       loadTx;
    logic       txValid;
    logic       stageWr;
    logic       commit;
    logic [1:0] sel;
  } ctrlStbT;

  function automatic logic [LEN_W-1:0] recLen(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd6;
    endcase
  endfunction

  function automatic int recBase(input int s);
    if (s == 0) return 0;
    else if (s == 1) return 1;
    else return 3;
  endfunction

  function automatic int recOfByte(input int g);
    if (g < 1) return 0;
    else if (g < 3) return 1;
    else return 2;
  endfunction

  // constant records served on reads
  function automatic logic [7:0] tgtByte(input logic [1:0] s, input logic [2:0] i);
    case (s)
      2'd0: return 8'd12;
      2'd1: return (i == 3'd0) ? 8'd15 : 8'd16;
      default: begin
        case (i)
          3'd0: return 8'h41;
          3'd1: return 8'h42;
          3'd2: return 8'h43;
          3'd3: return 8'h44;
          3'd4: return 8'h31;
          default: return 8'h32;
        endcase
      end
    endcase
  endfunction
endpackage

// File: rtl/i2cr_sync.sv
`timescale 1ns/1ps
module i2cr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclPipe[SYNC_STAGES-1];
      sdaD    <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/i2cr_data.sv
`timescale 1ns/1ps
module i2cr_data
  import i2cr_pkg::*;
#(
  parameter int STAGE_DEPTH = 20,
  parameter int IDX_W       = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStbT                stb,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   sdaS,
  output logic [7:0]             rxNext,
  output logic                   txMsb,
  output logic [REC_BYTES*8-1:0] rxRecords
);
  logic [7:0] shiftReg;
  logic [7:0] txShift;
  logic [7:0] stage [STAGE_DEPTH];
  logic [7:0] rec   [REC_BYTES];

  assign rxNext = {shiftReg[6:0], sdaS};
  assign txMsb  = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txShift  <= 8'hFF;
    end else begin
      if (stb.shiftIn) shiftReg <= rxNext;
      if (stb.loadTx)
        txShift <= stb.txValid ? tgtByte(stb.sel, idx[2:0]) : 8'hFF;
      else if (stb.shiftOut)
        txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGE_DEPTH; k++) stage[k] <= '0;
    end else if (stb.stageWr) begin
      stage[idx] <= rxNext;
    end
  end

  // one commit copies the whole staged record into its slot
  for (genvar g = 0; g < REC_BYTES; g++) begin : g_rec
    localparam int OWN = recOfByte(g);
    localparam int OFS = g - recBase(OWN);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rec[g] <= '0;
      else if (stb.commit && stb.sel == 2'(OWN))
        rec[g] <= stage[OFS];
    end
    assign rxRecords[g*8 +: 8] = rec[g];
  end
endmodule

// File: rtl/i2cr_ctrl.sv
`timescale 1ns/1ps
module i2cr_ctrl
  import i2cr_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h48,
  parameter int         IDX_W       = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic             sdaS,
  input  logic [7:0]       rxNext,
  input  logic             txMsb,
  output ctrlStbT          stb,
  output logic [IDX_W-1:0] idx,
  output logic             sdaOe,
  output logic             donePulse,
  output logic             startFlag,
  output logic             stopFlag
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_FALL, ST_ACK_HOLD, ST_WR,
    ST_RD, ST_RD_ACK, ST_RD_ACKH, ST_IGNORE
  } stateT;

  stateT             state, stateN;
  logic [2:0]        bitCnt, bitCntN;
  logic              isRead, isReadN;
  logic              ackOk, ackOkN;
  modeT              mode, modeN;
  logic [1:0]        sel, selN;
  logic [LEN_W-1:0]  remain, remainN;
  logic [IDX_W-1:0]  idxN;
  logic              ackDrv, ackDrvN;
  logic              commitQ, commitN;
  logic              doneQ, doneN;
  logic              startFN, stopFN;

  always_comb begin
    stateN  = state;
    bitCntN = bitCnt;
    isReadN = isRead;
    ackOkN  = ackOk;
    modeN   = mode;
    selN    = sel;
    remainN = remain;
    idxN    = idx;
    ackDrvN = ackDrv;
    commitN = 1'b0;
    doneN   = 1'b0;
    startFN = startFlag;
    stopFN  = stopFlag;
    stb         = '0;
    stb.sel     = sel;
    stb.commit  = commitQ;

    if (stopEv) begin
      stateN  = ST_IDLE;
      ackDrvN = 1'b0;
      stopFN  = 1'b1;
      startFN = 1'b0;
    end else if (startEv) begin
      stateN  = ST_ADDR;
      bitCntN = '0;
      ackDrvN = 1'b0;
      startFN = 1'b1;
      stopFN  = 1'b0;
    end else begin
      case (state)
        ST_ADDR: if (sclRise) begin
          stb.shiftIn = 1'b1;
          if (bitCnt == 3'd7) begin
            if (rxNext[7:1] == TARGET_ADDR) begin
              isReadN = rxNext[0];
              stateN  = ST_ACK_FALL;
            end else begin
              stateN = ST_IGNORE;
            end
          end else begin
            bitCntN = bitCnt + 3'd1;
          end
        end
        ST_WR: if (sclRise) begin
          stb.shiftIn = 1'b1;
          if (bitCnt == 3'd7) begin
            stateN = ST_ACK_FALL;
            case (mode)
              MODE_CMD: begin
                if (rxNext < 8'd3) begin
                  modeN   = MODE_TX;
                  selN    = rxNext[1:0];
                  remainN = recLen(rxNext[1:0]);
                  idxN    = '0;
                end else if (rxNext < 8'd6) begin
                  modeN   = MODE_RX;
                  selN    = rxNext[1:0] - 2'd3;
                  remainN = recLen(rxNext[1:0] - 2'd3);
                  idxN    = '0;
                end
              end
              MODE_RX: begin
                stb.stageWr = 1'b1;
                idxN        = idx + 1'b1;
                if (remain == 3'd1) begin
                  commitN = 1'b1;
                  doneN   = 1'b1;
                  modeN   = MODE_CMD;
                end else begin
                  remainN = remain - 3'd1;
                end
              end
              default: ;
            endcase
          end else begin
            bitCntN = bitCnt + 3'd1;
          end
        end
        ST_ACK_FALL: if (sclFall) begin
          ackDrvN = 1'b1;
          stateN  = ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (sclFall) begin
          ackDrvN = 1'b0;
          bitCntN = '0;
          if (isRead) begin
            stb.loadTx  = 1'b1;
            stb.txValid = (mode == MODE_TX);
            stateN      = ST_RD;
          end else begin
            stateN = ST_WR;
          end
        end
        ST_RD: if (sclFall) begin
          if (bitCnt == 3'd7) begin
            stateN = ST_RD_ACK;
          end else begin
            stb.shiftOut = 1'b1;
            bitCntN      = bitCnt + 3'd1;
          end
        end
        ST_RD_ACK: if (sclRise) begin
          ackOkN = ~sdaS;
          stateN = ST_RD_ACKH;
          if (mode == MODE_TX) begin
            if (remain == 3'd1) begin
              modeN = MODE_CMD;
              doneN = 1'b1;
            end else if (sdaS) begin
              modeN = MODE_CMD;
            end else begin
              remainN = remain - 3'd1;
              idxN    = idx + 1'b1;
            end
          end
        end
        ST_RD_ACKH: if (sclFall) begin
          if (ackOk) begin
            stb.loadTx  = 1'b1;
            stb.txValid = (mode == MODE_TX);
            bitCntN     = '0;
            stateN      = ST_RD;
          end else begin
            stateN = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      ackOk     <= 1'b0;
      mode      <= MODE_CMD;
      sel       <= '0;
      remain    <= '0;
      idx       <= '0;
      ackDrv    <= 1'b0;
      commitQ   <= 1'b0;
      doneQ     <= 1'b0;
      startFlag <= 1'b0;
      stopFlag  <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitCntN;
      isRead    <= isReadN;
      ackOk     <= ackOkN;
      mode      <= modeN;
      sel       <= selN;
      remain    <= remainN;
      idx       <= idxN;
      ackDrv    <= ackDrvN;
      commitQ   <= commitN;
      doneQ     <= doneN;
      startFlag <= startFN;
      stopFlag  <= stopFN;
    end
  end

  assign sdaOe     = ackDrv | ((state == ST_RD) & ~txMsb);
  assign donePulse = doneQ;
endmodule

// File: rtl/i2c_cmd_responder.sv
`timescale 1ns/1ps
module i2c_cmd_responder
  import i2cr_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h48,
  parameter int         STAGE_DEPTH = 20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaOe,
  output logic [REC_BYTES*8-1:0] rxRecords,
  output logic                   donePulse,
  output logic                   startFlag,
  output logic                   stopFlag
);
  localparam int IDX_W = $clog2(STAGE_DEPTH);

  logic             sclS, sdaS, sclRise, sclFall, startEv, stopEv;
  logic [7:0]       rxNext;
  logic             txMsb;
  ctrlStbT          stb;
  logic [IDX_W-1:0] idx;

  i2cr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  i2cr_ctrl #(.TARGET_ADDR(TARGET_ADDR), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaS(sdaS), .rxNext(rxNext),
    .txMsb(txMsb), .stb(stb), .idx(idx), .sdaOe(sdaOe),
    .donePulse(donePulse), .startFlag(startFlag), .stopFlag(stopFlag)
  );

  i2cr_data #(.STAGE_DEPTH(STAGE_DEPTH), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .sdaS(sdaS),
    .rxNext(rxNext), .txMsb(txMsb), .rxRecords(rxRecords)
  );
endmodule

// File: rtl/i2cr_checker.sv
`timescale 1ns/1ps
module i2cr_checker
  import i2cr_pkg::*;
#(
  parameter int STAGE_DEPTH = 20,
  parameter int IDX_W       = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclS,
  input logic             stopEv,
  input logic             sdaOe,
  input logic             donePulse,
  input logic             startFlag,
  input logic             stopFlag,
  input ctrlStbT          stb,
  input logic [IDX_W-1:0] idx
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(startFlag && stopFlag)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R10
  AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> $past(stb.stageWr)); // R4
  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stb.stageWr |-> (int'(idx) < STAGE_DEPTH)); // R4
  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe)); // R7
  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe); // R1
endmodule

bind i2c_cmd_responder i2cr_checker #(.STAGE_DEPTH(STAGE_DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .stopEv(stopEv), .sdaOe(sdaOe),
  .donePulse(donePulse), .startFlag(startFlag), .stopFlag(stopFlag),
  .stb(stb), .idx(idx)
);

// File: tb/i2c_cmd_responder_bench.sv
`timescale 1ns/1ps
module i2c_cmd_responder_bench;
  localparam int QTR = 10;
  localparam logic [6:0] OWN_ADDR = 7'h48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, donePulse, startFlag, stopFlag;
  logic [71:0] rxRecords;
  wire sdaLine = sdaM & ~sdaOe;

  always #2.5 clk = ~clk;

  i2c_cmd_responder u_i2c_cmd_responder (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .rxRecords(rxRecords), .donePulse(donePulse),
    .startFlag(startFlag), .stopFlag(stopFlag)
  );

  int checks = 0, errors = 0;
  int doneCount = 0, doneExp = 0;
  bit busy = 1'b1, oeSeen = 1'b0, finished = 1'b0;

  // behavioural model
  logic [7:0] mctl [9];
  logic [7:0] mstage [20];
  int mMode = 0, mSel = 0, mRem = 0, mIdx = 0;
  bit mStartF = 0, mStopF = 0;
  logic [7:0] wq[$];

  function automatic int recLen(int s); return (s == 0) ? 1 : (s == 1) ? 2 : 6; endfunction
  function automatic int recBase(int s); return (s == 0) ? 0 : (s == 1) ? 1 : 3; endfunction
  function automatic logic [7:0] ownByte(int s, int i);
    logic [7:0] r2 [6];
    r2 = '{8'h41, 8'h42, 8'h43, 8'h44, 8'h31, 8'h32};
    if (s == 0) return 8'd12;
    if (s == 1) return (i == 0) ? 8'd15 : 8'd16;
    return r2[i];
  endfunction
  function automatic logic [71:0] expRec();
    logic [71:0] v;
    for (int g = 0; g < 9; g++) v[g*8 +: 8] = mctl[g];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (donePulse) doneCount++;
    if (busy && sdaOe) oeSeen = 1'b1;
    if (rstN && !busy) begin
      chk(rxRecords == expRec(), "R3 record image", rxRecords, expRec());
      chk(startFlag == mStartF && stopFlag == mStopF, "R9 flags idle",
          {startFlag, stopFlag}, {mStartF, mStopF});
    end
  end

  task automatic waitQ(); repeat (QTR) @(negedge clk); endtask
  task automatic busStart();
    sdaM = 1; waitQ(); sclM = 1; waitQ(); sdaM = 0; waitQ(); sclM = 0; waitQ();
    mStartF = 1; mStopF = 0;
  endtask
  task automatic busStop();
    sdaM = 0; waitQ(); sclM = 1; waitQ(); sdaM = 1; waitQ(); waitQ();
    mStopF = 1; mStartF = 0;
  endtask
  task automatic sendBit(input logic b);
    sdaM = b; waitQ(); sclM = 1; waitQ(); waitQ(); sclM = 0; waitQ();
  endtask
  task automatic readBit(output logic v);
    sdaM = 1; waitQ(); sclM = 1; waitQ(); v = sdaLine; waitQ(); sclM = 0; waitQ();
  endtask
  task automatic sendByte(input logic [7:0] b, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    readBit(v);
    ack = ~v;
  endtask
  task automatic readByte(output logic [7:0] b, input bit ackIt);
    logic v;
    for (int i = 7; i >= 0; i--) begin readBit(v); b[i] = v; end
    sendBit(!ackIt);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
    chk(doneCount == doneExp, "R10 done pulse count", 72'(doneCount), 72'(doneExp));
    busy = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic modelWrite(input logic [7:0] b);
    if (mMode == 0) begin
      if (b < 3) begin mMode = 1; mSel = b; mRem = recLen(b); mIdx = 0; end
      else if (b < 6) begin mMode = 2; mSel = b - 3; mRem = recLen(b - 3); mIdx = 0; end
    end else if (mMode == 2) begin
      mstage[mIdx] = b; mIdx++; mRem--;
      if (mRem == 0) begin
        for (int k = 0; k < recLen(mSel); k++) mctl[recBase(mSel) + k] = mstage[k];
        doneExp++; mMode = 0;
      end
    end
  endtask

  task automatic doWrite(input logic [6:0] addr, input bit withStop);
    bit ack;
    bit match;
    match = (addr == OWN_ADDR);
    busy = 1; oeSeen = 0;
    busStart();
    chk(startFlag && !stopFlag, "R9 start sets flag", {startFlag, stopFlag}, 2'b10);
    sendByte({addr, 1'b0}, ack);
    chk(ack == match, match ? "R7 address ack" : "R1 foreign address nack", 72'(ack), 72'(match));
    foreach (wq[i]) begin
      sendByte(wq[i], ack);
      chk(ack == match, match ? "R7 data ack" : "R1 ignored data", 72'(ack), 72'(match));
      if (match) modelWrite(wq[i]);
    end
    if (!match) chk(!oeSeen, "R1 sda never driven", 72'(oeSeen), 72'(0));
    if (withStop) begin
      busStop();
      chk(stopFlag && !startFlag, "R9 stop sets flag", {startFlag, stopFlag}, 2'b01);
      settle();
    end
  endtask

  task automatic doRead(input logic [6:0] addr, input int n, input string tag);
    bit ack;
    logic [7:0] b, e;
    busy = 1; oeSeen = 0;
    busStart();
    sendByte({addr, 1'b1}, ack);
    chk(ack == (addr == OWN_ADDR), "R1 read address ack", 72'(ack), 72'(addr == OWN_ADDR));
    if (addr == OWN_ADDR) begin
      for (int k = 0; k < n; k++) begin
        e = (mMode == 1) ? ownByte(mSel, mIdx) : 8'hFF;
        readByte(b, k < n - 1);
        chk(b == e, tag, 72'(b), 72'(e));
        if (mMode == 1) begin
          if (mRem == 1) begin mMode = 0; doneExp++; end
          else if (k == n - 1) mMode = 0;
          else begin mRem--; mIdx++; end
        end
      end
    end else begin
      chk(!oeSeen, "R1 no drive on foreign read", 72'(oeSeen), 72'(0));
    end
    busStop();
    settle();
  endtask

  task automatic q(input int n, input logic [7:0] b0 = 0, input logic [7:0] b1 = 0,
                   input logic [7:0] b2 = 0, input logic [7:0] b3 = 0,
                   input logic [7:0] b4 = 0, input logic [7:0] b5 = 0, input logic [7:0] b6 = 0);
    logic [7:0] a [7];
    a = '{b0, b1, b2, b3, b4, b5, b6};
    wq.delete();
    for (int i = 0; i < n; i++) wq.push_back(a[i]);
  endtask

  task automatic cmdRead(input logic [7:0] cmd, input int n, input string tag);
    q(1, cmd);
    doWrite(OWN_ADDR, 1'b0);
    doRead(OWN_ADDR, n, tag);
  endtask

  initial begin
    for (int g = 0; g < 9; g++) mctl[g] = 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(rxRecords == 72'h0 && !sdaOe && !donePulse, "R11 reset outputs",
        {rxRecords[63:0], sdaOe, donePulse}, 0);
    chk(!startFlag && !stopFlag, "R9 flags after reset", {startFlag, stopFlag}, 0);
    busy = 0;
    repeat (5) @(negedge clk);

    q(2, 8'd3, 8'hA5);                    doWrite(OWN_ADDR, 1);   // R3
    q(3, 8'd4, 8'h11, 8'h22);             doWrite(OWN_ADDR, 1);   // R3
    q(7, 8'd5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06); doWrite(OWN_ADDR, 1); // R3
    cmdRead(8'd0, 1, "R2 record 0 byte");
    cmdRead(8'd1, 2, "R2 record 1 byte");
    cmdRead(8'd2, 6, "R2 record 2 byte");

    // R4: partial write held back across a stop
    q(4, 8'd5, 8'hE1, 8'hE2, 8'hE3);      doWrite(OWN_ADDR, 1);
    chk(rxRecords[71:24] == 48'h060504030201, "R4 record unchanged after partial",
        rxRecords, expRec());
    q(3, 8'hE4, 8'hE5, 8'hE6);            doWrite(OWN_ADDR, 1);
    chk(rxRecords[71:24] == 48'hE6E5E4E3E2E1, "R4 record committed whole",
        rxRecords, expRec());

    // R5: count exhausted, next byte is a command; extra read bytes give 0xFF
    q(5, 8'd4, 8'h33, 8'h44, 8'd3, 8'h55); doWrite(OWN_ADDR, 1);
    chk(rxRecords[7:0] == 8'h55, "R5 command after record", rxRecords[7:0], 8'h55);
    cmdRead(8'd0, 3, "R5 read past record");

    // R6: invalid code ignored
    q(3, 8'd9, 8'd3, 8'h5A);              doWrite(OWN_ADDR, 1);
    chk(rxRecords[7:0] == 8'h5A, "R6 invalid code ignored", rxRecords[7:0], 8'h5A);
    q(1, 8'hFF);                          doWrite(OWN_ADDR, 1);
    doRead(OWN_ADDR, 1, "R6 no arm after invalid code");

    // R8: early NACK ends read
    cmdRead(8'd2, 2, "R8 early nack read");
    doRead(OWN_ADDR, 2, "R8 read after early end");
    q(2, 8'd3, 8'h77);                    doWrite(OWN_ADDR, 1);
    chk(rxRecords[7:0] == 8'h77, "R8 command wait after nack", rxRecords[7:0], 8'h77);

    // R1: foreign address
    q(2, 8'd3, 8'h99);                    doWrite(7'h49, 1);
    chk(rxRecords[7:0] == 8'h77, "R1 foreign write ignored", rxRecords[7:0], 8'h77);
    doRead(7'h10, 1, "R1 foreign read");

    // R12: writes while read armed are discarded
    q(3, 8'd1, 8'd3, 8'h44);              doWrite(OWN_ADDR, 1);
    doRead(OWN_ADDR, 2, "R12 armed read survives writes");
    chk(rxRecords[7:0] == 8'h77, "R12 record untouched", rxRecords[7:0], 8'h77);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule